// File: doc/BRIEF.md
# Character Display Parallel Bus Engine

This block runs one transfer at a time on the 8-bit parallel bus of a character display module. The bus has a register-select line, a direction line, an enable strobe and eight data lines. The host side offers a request over a valid/ready handshake. A request carries the register-select value, a read flag and a byte to write. When the bus cycle is over, the block returns a one-clock `done` pulse. For a read, the captured byte comes back on `rdata`.

The display's minimum nanosecond limits become clock counts at elaboration time, using the `CLK_HZ` parameter. These limits are the strobe cycle, the strobe width, the address setup and hold, the write-data setup and hold, and the read-data delay. Each count is the ceiling of the time multiplied by the frequency, and is never less than one clock. The data lines are split into a drive value, a drive enable and an input. The pad or tristate buffer that joins them sits outside the block. The rules for back-pressure are as follows. `req_ready` is high only while no transfer is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_valid` may stay high across the `done` cycle, and the next request is then taken in that same cycle.

Top module: `lcd_bus_engine`

## Requirements
- R1: After reset, `lcd_e` is low, `lcd_db_oe` is low, `done` is low and `req_ready` is high.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from that clock until the `done` cycle, in which it is high again. A request still pending then is taken in the `done` cycle.
- R3: `lcd_rs` carries the request's register-select value. `lcd_rw` is 1 for a read and 0 for a write. Both stay stable from the clock after acceptance until the hold phase ends.
- R4: `lcd_e` rises after the accepted request has been on `lcd_rs`/`lcd_rw` for at least the setup count (1 clock at 250 MHz).
- R5: `lcd_e` stays high for the largest of the strobe-width, write-data-setup and read-delay counts. At 250 MHz this is 35 clocks.
- R6: `lcd_db_oe` is high only for write transfers, from the clock after acceptance until the end of the hold phase. During that whole time `lcd_db_out` holds the request's byte. For reads, and while idle, `lcd_db_oe` is low.
- R7: After `lcd_e` falls, the lines `lcd_rs`, `lcd_rw`, `lcd_db_out` and `lcd_db_oe` keep their values for the larger of the address-hold and data-hold counts. At 250 MHz this is 3 clocks.
- R8: On a read, the value on `lcd_db_in` during the last clock of the `lcd_e` high phase is captured. That is the 35th clock, which is at least 100 ns after the rise. The value appears on `rdata` by the `done` cycle and holds until the next read completes. Writes leave `rdata` unchanged.
- R9: `done` is high for exactly one clock. The first clock with `done` high comes exactly the cycle count (300 clocks at 250 MHz) after the first clock with `lcd_e` high.
- R10: A request offered while a transfer is in progress has no effect. The bus lines keep the values of the running transfer, and no extra transfer follows once it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_rs | input | 1 | Register select for the transfer (1 data, 0 instruction) |
| req_read | input | 1 | 1 read from the display, 0 write to it |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock pulse when the transfer cycle is complete |
| rdata | output | 8 | Byte captured by the most recent read |
| lcd_rs | output | 1 | Register-select line |
| lcd_rw | output | 1 | Direction line (1 read, 0 write) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Value driven onto the data lines |
| lcd_db_oe | output | 1 | Drive enable for the data lines |
| lcd_db_in | input | 8 | Value seen on the data lines |

## Verification
Two functions can fall in the same cycle: the completion pulse of one transfer and the acceptance of the next. The bench provokes this by keeping `req_valid` high across two back-to-back requests with different register-select values and bytes. It then judges three things. The second request must be taken in the `done` cycle. The gap from one strobe rise to the next must equal the cycle count plus one idle clock plus the setup count. The second transfer must carry its own select value and byte, with nothing left over from the first. The read model puts junk on the data lines until the read delay has passed and again after the strobe falls. A capture made at the wrong clock therefore shows up as a wrong `rdata`.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD,
    PH_TAIL
  } phase_t;

  // Ceiling conversion of a nanosecond limit to clocks, at least one clock.
  function automatic int unsigned ns_to_clk(input longint unsigned t_ns,
                                            input longint unsigned clk_hz);
    longint unsigned c;
    c = (t_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 64'd1) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/lcd_cycle_timer.sv
module lcd_cycle_timer #(
  parameter int unsigned W     = 9,
  parameter int unsigned LIMIT = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic reached
);
  localparam logic [W-1:0] SAT = '1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= SAT;
    end else if (clear) begin
      cnt <= '0;
    end else if (cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  // cnt holds the clocks elapsed since the strobe rose
  assign reached = (cnt >= W'(LIMIT - 1));
endmodule

// File: rtl/lcd_bus_fsm.sv
module lcd_bus_fsm
  import lcd_bus_pkg::*;
#(
  parameter int unsigned W       = 9,
  parameter int unsigned AS_CLK  = 1,
  parameter int unsigned HI_CLK  = 35,
  parameter int unsigned HLD_CLK = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         ph_last,
  input  logic         cyc_reached,
  output phase_t       phase,
  output logic         ph_load,
  output logic [W-1:0] ph_val,
  output logic         cyc_clear,
  output logic         accept,
  output logic         capture,
  output logic         done
);
  phase_t nxt;
  logic   done_nxt;

  always_comb begin
    nxt       = phase;
    ph_load   = 1'b0;
    ph_val    = '0;
    cyc_clear = 1'b0;
    capture   = 1'b0;
    done_nxt  = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        nxt     = PH_SETUP;
        ph_load = 1'b1;
        ph_val  = W'(AS_CLK);
      end
      PH_SETUP: if (ph_last) begin
        nxt       = PH_HIGH;
        ph_load   = 1'b1;
        ph_val    = W'(HI_CLK);
        cyc_clear = 1'b1;
      end
      PH_HIGH: if (ph_last) begin
        nxt     = PH_HOLD;
        ph_load = 1'b1;
        ph_val  = W'(HLD_CLK);
        capture = 1'b1;
      end
      PH_HOLD: if (ph_last) begin
        if (cyc_reached) begin
          nxt      = PH_IDLE;
          done_nxt = 1'b1;
        end else begin
          nxt = PH_TAIL;
        end
      end
      PH_TAIL: if (cyc_reached) begin
        nxt      = PH_IDLE;
        done_nxt = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign accept = (phase == PH_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      done  <= done_nxt;
    end
  end
endmodule

// File: rtl/lcd_bus_datapath.sv
module lcd_bus_datapath (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       capture,
  input  logic       req_rs,
  input  logic       req_read,
  input  logic [7:0] req_wdata,
  input  logic [7:0] db_in,
  output logic       rs_q,
  output logic       rd_q,
  output logic [7:0] wdata_q,
  output logic [7:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q    <= 1'b0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        rs_q    <= req_rs;
        rd_q    <= req_read;
        wdata_q <= req_wdata;
      end
      if (capture && rd_q) rdata_q <= db_in;
    end
  end
endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned     T_CYC_NS = 1200,
  parameter int unsigned     T_PW_NS  = 140,
  parameter int unsigned     T_AS_NS  = 0,
  parameter int unsigned     T_AH_NS  = 10,
  parameter int unsigned     T_DSW_NS = 40,
  parameter int unsigned     T_DH_NS  = 10,
  parameter int unsigned     T_DDR_NS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_read,
  input  logic [7:0] req_wdata,
  output logic       done,
  output logic [7:0] rdata,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [7:0] lcd_db_in
);
  localparam int unsigned AS_CLK  = ns_to_clk(T_AS_NS, CLK_HZ);
  localparam int unsigned HI_CLK  = max2(ns_to_clk(T_PW_NS, CLK_HZ),
                                         max2(ns_to_clk(T_DSW_NS, CLK_HZ),
                                              ns_to_clk(T_DDR_NS, CLK_HZ)));
  localparam int unsigned HLD_CLK = max2(ns_to_clk(T_AH_NS, CLK_HZ),
                                         ns_to_clk(T_DH_NS, CLK_HZ));
  localparam int unsigned CYC_CLK = ns_to_clk(T_CYC_NS, CLK_HZ);
  localparam int unsigned MAX_CLK = max2(max2(AS_CLK, HI_CLK), max2(HLD_CLK, CYC_CLK));
  localparam int unsigned CW      = $clog2(MAX_CLK + 2);

  phase_t        phase;
  logic          ph_load, ph_last, cyc_clear, cyc_reached, accept, capture;
  logic [CW-1:0] ph_val;
  logic          rd_q;

  lcd_bus_fsm #(
    .W(CW), .AS_CLK(AS_CLK), .HI_CLK(HI_CLK), .HLD_CLK(HLD_CLK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .ph_last(ph_last), .cyc_reached(cyc_reached),
    .phase(phase), .ph_load(ph_load), .ph_val(ph_val),
    .cyc_clear(cyc_clear), .accept(accept), .capture(capture), .done(done)
  );

  lcd_phase_timer #(.W(CW)) u_ph_tmr (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .last(ph_last)
  );

  lcd_cycle_timer #(.W(CW), .LIMIT(CYC_CLK)) u_cyc_tmr (
    .clk(clk), .rst_n(rst_n), .clear(cyc_clear), .reached(cyc_reached)
  );

  lcd_bus_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_rs(req_rs), .req_read(req_read), .req_wdata(req_wdata),
    .db_in(lcd_db_in), .rs_q(lcd_rs), .rd_q(rd_q),
    .wdata_q(lcd_db_out), .rdata_q(rdata)
  );

  assign req_ready = (phase == PH_IDLE);
  assign lcd_rw    = rd_q;
  assign lcd_e     = (phase == PH_HIGH);
  assign lcd_db_oe = !rd_q && ((phase == PH_SETUP) || (phase == PH_HIGH) || (phase == PH_HOLD));
endmodule

// File: rtl/lcd_bus_engine_chk.sv
module lcd_bus_engine_chk #(
  parameter int unsigned HI_CLK  = 35,
  parameter int unsigned CYC_CLK = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [7:0] lcd_db_out,
  input logic       lcd_db_oe
);
  int unsigned e_run;
  int unsigned since_rise;
  logic        e_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_run      <= 0;
      since_rise <= 0;
      e_prev     <= 1'b0;
    end else begin
      e_prev <= lcd_e;
      e_run  <= lcd_e ? e_run + 1 : 0;
      if (lcd_e && !e_prev) since_rise <= 1;
      else if (since_rise != 0 && since_rise < 32'hFFFF_0000) since_rise <= since_rise + 1;
    end
  end

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !req_ready);
  a_r3_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && e_prev) |-> ($stable(lcd_rs) && $stable(lcd_rw)));
  a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_e && e_prev) |-> (e_run == HI_CLK));
  a_r6_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_db_oe |-> !lcd_rw);
  a_r7_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)
                      && $stable(lcd_db_oe)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_rise == CYC_CLK));
endmodule

bind lcd_bus_engine lcd_bus_engine_chk #(.HI_CLK(HI_CLK), .CYC_CLK(CYC_CLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
  .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe)
);

// File: tb/test_lcd_bus_engine.sv
`timescale 1ns/1ps
module test_lcd_bus_engine;
  // Expected counts at 250 MHz (4 ns): ceil(t*0.25), min 1
  localparam int EXP_AS  = 1;   // 0 ns
  localparam int EXP_HI  = 35;  // max(140,40,100) ns
  localparam int EXP_HLD = 3;   // max(10,10) ns
  localparam int EXP_CYC = 300; // 1200 ns
  localparam int GUARD   = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_rs = 1'b0, req_read = 1'b0;
  logic [7:0] req_wdata = '0, lcd_db_in = '0;
  logic       req_ready, done, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] rdata, lcd_db_out;
  int         n_chk = 0, n_err = 0, cyc_n = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  lcd_bus_engine i_lcd_bus_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_read(req_read), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Results of the last transfer
  int  r_setup_e, r_hi, r_hold, r_rise, r_done, r_bad_lines, r_bad_oe, r_done_w;

  // Waits for strobe, walks the transfer, models the display for reads.
  task automatic walk_xfer(input bit rs, input bit rd, input logic [7:0] wd,
                           input logic [7:0] rv);
    int g;
    r_hi = 0; r_hold = 0; r_bad_lines = 0; r_bad_oe = 0;
    g = 0;
    while (!lcd_e && g < GUARD) begin
      if (lcd_rs !== rs || lcd_rw !== rd) r_bad_lines++;
      if (lcd_db_oe !== !rd || (!rd && lcd_db_out !== wd)) r_bad_oe++;
      @(negedge clk); g++;
    end
    r_rise = cyc_n;
    while (lcd_e && g < GUARD) begin
      r_hi++;
      if (lcd_rs !== rs || lcd_rw !== rd) r_bad_lines++;
      if (lcd_db_oe !== !rd || (!rd && lcd_db_out !== wd)) r_bad_oe++;
      lcd_db_in = (r_hi > 25) ? rv : ~rv;
      @(negedge clk); g++;
    end
    lcd_db_in = ~rv;
    for (int i = 0; i < EXP_HLD; i++) begin
      if (lcd_rs !== rs || lcd_rw !== rd) r_bad_lines++;
      if (lcd_db_oe === !rd && (rd || lcd_db_out === wd)) r_hold++;
      @(negedge clk);
    end
    if (lcd_db_oe !== 1'b0) r_bad_oe++;
    while (!done && g < GUARD) begin
      @(negedge clk); g++;
    end
    r_done = cyc_n;
    @(negedge clk);
    r_done_w = done;
  endtask

  task automatic issue(input bit rs, input bit rd, input logic [7:0] wd);
    req_valid = 1'b1; req_rs = rs; req_read = rd; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    r_setup_e = lcd_e;
  endtask

  task automatic t_reset();
    chk(lcd_e == 1'b0, "R1 strobe low", lcd_e, 0);
    chk(lcd_db_oe == 1'b0, "R1 drive off", lcd_db_oe, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(req_ready == 1'b1, "R1 ready high", req_ready, 1);
  endtask

  task automatic t_write(input bit rs, input logic [7:0] wd);
    chk(req_ready == 1'b1, "R2 ready before write", req_ready, 1);
    issue(rs, 1'b0, wd);
    chk(r_setup_e == 0, "R4 setup before strobe", r_setup_e, 0);
    chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    walk_xfer(rs, 1'b0, wd, 8'h00);
    chk(r_bad_lines == 0, "R3 rs/rw on write", r_bad_lines, 0);
    chk(r_bad_oe == 0, "R6 write drive window", r_bad_oe, 0);
    chk(r_hi == EXP_HI, "R5 strobe width", r_hi, EXP_HI);
    chk(r_hold == EXP_HLD, "R7 hold after fall", r_hold, EXP_HLD);
    chk(r_done - r_rise == EXP_CYC, "R9 cycle length", r_done - r_rise, EXP_CYC);
    chk(r_done_w == 0, "R9 single done", r_done_w, 0);
  endtask

  task automatic t_read(input bit rs, input logic [7:0] rv);
    issue(rs, 1'b1, 8'h00);
    walk_xfer(rs, 1'b1, 8'h00, rv);
    chk(r_bad_lines == 0, "R3 rs/rw on read", r_bad_lines, 0);
    chk(r_bad_oe == 0, "R6 no drive on read", r_bad_oe, 0);
    chk(r_hi == EXP_HI, "R5 strobe width read", r_hi, EXP_HI);
    chk(rdata == rv, "R8 read capture", rdata, rv);
    chk(r_done - r_rise == EXP_CYC, "R9 read cycle length", r_done - r_rise, EXP_CYC);
  endtask

  task automatic t_write_keeps_rdata(input logic [7:0] prev);
    t_write(1'b1, 8'h3C);
    chk(rdata == prev, "R8 rdata kept over write", rdata, prev);
  endtask

  task automatic t_busy_ignored();
    int e_seen;
    issue(1'b0, 1'b0, 8'hA5);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_rs = 1'b1; req_read = 1'b1; req_wdata = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    chk(lcd_db_out == 8'hA5, "R10 byte unchanged", lcd_db_out, 8'hA5);
    chk(lcd_rs == 1'b0 && lcd_rw == 1'b0, "R10 lines unchanged", {lcd_rs, lcd_rw}, 0);
    walk_xfer(1'b0, 1'b0, 8'hA5, 8'h00);
    chk(r_bad_lines == 0 && r_bad_oe == 0, "R10 transfer intact", r_bad_lines + r_bad_oe, 0);
    e_seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (lcd_e) e_seen++;
      @(negedge clk);
    end
    chk(e_seen == 0, "R10 no extra transfer", e_seen, 0);
  endtask

  task automatic t_back_to_back();
    int rise1, rise2, g, acc_in_done;
    req_valid = 1'b1; req_rs = 1'b1; req_read = 1'b0; req_wdata = 8'h81;
    @(negedge clk);
    req_rs = 1'b0; req_wdata = 8'h18;  // second request waits behind the first
    g = 0;
    while (!lcd_e && g < GUARD) begin @(negedge clk); g++; end
    rise1 = cyc_n;
    chk(lcd_rs == 1'b1 && lcd_db_out == 8'h81, "R3 first request lines",
        {lcd_rs, lcd_db_out}, {1'b1, 8'h81});
    while (!done && g < GUARD) begin @(negedge clk); g++; end
    acc_in_done = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    chk(acc_in_done == 1, "R2 ready in done cycle", acc_in_done, 1);
    chk(req_ready == 1'b0, "R2 pending request taken", req_ready, 0);
    while (!lcd_e && g < GUARD) begin @(negedge clk); g++; end
    rise2 = cyc_n;
    chk(rise2 - rise1 == EXP_CYC + 1 + EXP_AS, "R2 rise to rise", rise2 - rise1,
        EXP_CYC + 1 + EXP_AS);
    chk(lcd_rs == 1'b0 && lcd_db_out == 8'h18 && lcd_db_oe,
        "R6 second request lines", {lcd_rs, lcd_db_out}, {1'b0, 8'h18});
    while (!done && g < GUARD) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(1'b0, 8'h38);
    t_write(1'b1, 8'hC7);
    t_read(1'b0, 8'h9E);
    t_read(1'b1, 8'h41);
    t_write_keeps_rdata(8'h41);
    t_busy_ignored();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule